// File: doc/BRIEF.md
# Debug Serial Port Shifter

This block is the serial end of a debug link between an external development tool and a processor. The tool drives a serial clock and a serial data line, and the block returns a serial data line. Both incoming lines are asynchronous to the system clock. On the parallel side, the block delivers each received word with its control flag and length flag. It also accepts one word at a time for transmission, using a valid/ready handshake.

When idle, the port holds its output high to show it can take a frame. The tool starts a frame with a high start bit, then sends a mode bit, a control bit and a data field. A mode bit of 0 selects 32 data bits and a mode bit of 1 selects 7 data bits. In the same clock periods, the port returns two status bits and a data field of the same length. This keeps the two directions bit-aligned. After each completed frame, the port stays busy (output low) until the processor side acknowledges the received word.

Top module: `dbgser_port`

## Requirements
- R1: During and right after a synchronous active-high reset, `serOut` is 1, `rxValid` is 0 and `txReady` is 1.
- R2: A frame begins only on a synchronised rising edge of `serClk` that samples `serIn` at 1 while the port is idle. Serial clock edges that sample `serIn` at 0 leave `serOut` at its idle level and deliver nothing.
- R3: In a frame, `serOut` carries two status bits: high code bit during the mode bit, low code bit during the control bit. Codes: 00 valid, 01 sequence error, 10 core interrupt, 11 null (no transmit word held). Priority: sequence error, then interrupt, then valid, then null.
- R4: Output data follows the status bits, least significant bit first, one bit per serial clock period. Mode 0 sends all 32 bits of the transmit word. Mode 1 sends its low 7 bits. Any status other than 00 sends zeros.
- R5: Received data is taken least significant bit first. In a 7-bit frame, `rxData[31:7]` is 0. `rxCtrl` gives the control bit and `rxShort` gives the mode bit of the frame.
- R6: After the last data bit of a frame without a sequence error, `rxValid` is high for exactly one system cycle, and `serOut` is low from that cycle on.
- R7: `rxAck` ends the busy state, and `serOut` returns to 1.
- R8: A frame started while busy reports status 01. It produces no `rxValid`, leaves the port busy and does not consume a held transmit word.
- R9: With `coreIrq` high at frame start, the status is 10, the data sent is zero and the held transmit word is kept.
- R10: `txReady` is high exactly when no transmit word is held. A word is taken when `txValid` and `txReady` are both high. A frame with status 00 consumes it and `txReady` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| serClk | input | 1 | Serial clock from the tool, asynchronous |
| serIn | input | 1 | Serial data from the tool, asynchronous |
| serOut | output | 1 | Serial data to the tool (ready/status/data) |
| coreIrq | input | 1 | Core interrupt pending, reported as status 10 |
| rxData | output | 32 | Received word, valid with rxValid |
| rxCtrl | output | 1 | Control bit of the received frame |
| rxShort | output | 1 | 1 when the received frame was 7-bit |
| rxValid | output | 1 | One-cycle pulse per delivered word |
| rxAck | input | 1 | Processor side has taken the word; port ready again |
| txData | input | 32 | Word to transmit |
| txValid | input | 1 | txData is valid |
| txReady | output | 1 | Transmit holding register is empty |

## Verification
The bench uses the default parameters: a 32-bit long field, a 7-bit short field and two synchroniser stages. With these values, one bench run covers both frame lengths and the upper-bit clearing of short words. The serial clock runs at 16 system cycles per period, so every bit crosses the synchroniser and the output settles before the tool samples it. The two-stage depth sets the edge-to-output latency the bench relies on.

// File: rtl/dbgser_pkg.sv
package dbgser_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_MODE, PH_CTRL, PH_DATA} phase_e;

  typedef struct packed {
    logic startFrame;
    logic takeMode;
    logic takeCtrl;
    logic takeData;
    logic lastData;
  } strobe_t;

  localparam logic [1:0] STAT_VALID  = 2'b00;
  localparam logic [1:0] STAT_SEQERR = 2'b01;
  localparam logic [1:0] STAT_IRQ    = 2'b10;
  localparam logic [1:0] STAT_NULL   = 2'b11;
endpackage

// File: rtl/dbgser_sync.sv
module dbgser_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/dbgser_ctrl.sv
module dbgser_ctrl
  import dbgser_pkg::*;
#(
  parameter int LONG_W  = 32,
  parameter int SHORT_W = 7
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    sclkSync,
  input  logic    sdiSync,
  input  logic    modeShort,
  output strobe_t strobe,
  output logic    inFrame
);
  localparam int CNT_W = $clog2(LONG_W);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LONG_W - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_W - 1);

  phase_e phase;
  logic [CNT_W-1:0] bitCnt;
  logic sclkPrev;
  logic edgeSeen;
  logic [CNT_W-1:0] lastIdx;

  assign edgeSeen = sclkSync & ~sclkPrev;
  assign lastIdx  = modeShort ? LAST_SHORT : LAST_LONG;
  assign inFrame  = (phase != PH_IDLE);

  always_comb begin
    strobe = '0;
    case (phase)
      PH_IDLE: strobe.startFrame = edgeSeen & sdiSync;
      PH_MODE: strobe.takeMode   = edgeSeen;
      PH_CTRL: strobe.takeCtrl   = edgeSeen;
      PH_DATA: begin
        strobe.takeData = edgeSeen;
        strobe.lastData = edgeSeen && (bitCnt == lastIdx);
      end
      default: strobe = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      bitCnt   <= '0;
      sclkPrev <= 1'b0;
    end else begin
      sclkPrev <= sclkSync;
      if (strobe.startFrame) phase <= PH_MODE;
      if (strobe.takeMode)   phase <= PH_CTRL;
      if (strobe.takeCtrl) begin
        phase  <= PH_DATA;
        bitCnt <= '0;
      end
      if (strobe.takeData) bitCnt <= bitCnt + 1'b1;
      if (strobe.lastData) phase <= PH_IDLE;
    end
  end
endmodule

// File: rtl/dbgser_dpath.sv
module dbgser_dpath
  import dbgser_pkg::*;
#(
  parameter int LONG_W  = 32,
  parameter int SHORT_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  input  logic              inFrame,
  input  logic              sdiSync,
  input  logic              coreIrq,
  input  logic              rxAck,
  input  logic [LONG_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic [LONG_W-1:0] rxData,
  output logic              rxCtrl,
  output logic              rxShort,
  output logic              rxValid,
  output logic              modeShort,
  output logic              serOut
);
  localparam int GAP = LONG_W - SHORT_W;

  logic [LONG_W-1:0] txHold, txShift, rxShift, rxNext;
  logic txFull, rxPending, frameErr, ctrlReg, outBit;
  logic [1:0] statusCode, statusNext;

  assign txReady = ~txFull;
  assign rxNext  = {sdiSync, rxShift[LONG_W-1:1]};
  assign serOut  = inFrame ? outBit : ~rxPending;

  always_comb begin
    if (rxPending)   statusNext = STAT_SEQERR;
    else if (coreIrq) statusNext = STAT_IRQ;
    else if (txFull) statusNext = STAT_VALID;
    else             statusNext = STAT_NULL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txHold     <= '0;
      txShift    <= '0;
      rxShift    <= '0;
      rxData     <= '0;
      txFull     <= 1'b0;
      rxPending  <= 1'b0;
      frameErr   <= 1'b0;
      ctrlReg    <= 1'b0;
      modeShort  <= 1'b0;
      outBit     <= 1'b1;
      statusCode <= STAT_NULL;
      rxCtrl     <= 1'b0;
      rxShort    <= 1'b0;
      rxValid    <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (rxAck) rxPending <= 1'b0;

      if (strobe.startFrame) begin
        statusCode <= statusNext;
        outBit     <= statusNext[1];
        frameErr   <= rxPending;
        rxShift    <= '0;
        if (statusNext == STAT_VALID) begin
          txShift <= txHold;
          txFull  <= 1'b0;
        end else begin
          txShift <= '0;
        end
      end

      if (strobe.takeMode) begin
        modeShort <= sdiSync;
        outBit    <= statusCode[0];
      end

      if (strobe.takeCtrl) begin
        ctrlReg <= sdiSync;
        outBit  <= txShift[0];
        txShift <= txShift >> 1;
      end

      if (strobe.takeData) begin
        rxShift <= rxNext;
        if (!strobe.lastData) begin
          outBit  <= txShift[0];
          txShift <= txShift >> 1;
        end else if (!frameErr) begin
          rxData    <= modeShort ? (rxNext >> GAP) : rxNext;
          rxCtrl    <= ctrlReg;
          rxShort   <= modeShort;
          rxValid   <= 1'b1;
          rxPending <= 1'b1;
        end
      end

      if (txValid && !txFull) begin
        txHold <= txData;
        txFull <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbgser_port.sv
module dbgser_port
  import dbgser_pkg::*;
#(
  parameter int LONG_W      = 32,
  parameter int SHORT_W     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serClk,
  input  logic              serIn,
  output logic              serOut,
  input  logic              coreIrq,
  output logic [LONG_W-1:0] rxData,
  output logic              rxCtrl,
  output logic              rxShort,
  output logic              rxValid,
  input  logic              rxAck,
  input  logic [LONG_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady
);
  logic sclkSync, sdiSync, modeShort, inFrame;
  strobe_t strobe;

  dbgser_sync #(.STAGES(SYNC_STAGES)) u_sclk (
    .clk(clk), .rst(rst), .asyncIn(serClk), .syncOut(sclkSync));
  dbgser_sync #(.STAGES(SYNC_STAGES)) u_sdi (
    .clk(clk), .rst(rst), .asyncIn(serIn), .syncOut(sdiSync));

  dbgser_ctrl #(.LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_ctrl (
    .clk(clk), .rst(rst), .sclkSync(sclkSync), .sdiSync(sdiSync),
    .modeShort(modeShort), .strobe(strobe), .inFrame(inFrame));

  dbgser_dpath #(.LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .inFrame(inFrame),
    .sdiSync(sdiSync), .coreIrq(coreIrq), .rxAck(rxAck),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxCtrl(rxCtrl), .rxShort(rxShort),
    .rxValid(rxValid), .modeShort(modeShort), .serOut(serOut));
endmodule

// File: rtl/dbgser_port_chk.sv
module dbgser_port_chk #(
  parameter int LONG_W  = 32,
  parameter int SHORT_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              serOut,
  input logic              rxValid,
  input logic              rxShort,
  input logic [LONG_W-1:0] rxData,
  input logic              txReady,
  input logic              txValid
);
  logic rstSeen;

  always_ff @(posedge clk) rstSeen <= rst;

  // R1: outputs sit at their idle values in the cycle after reset is sampled
  always @(posedge clk) begin
    if (rstSeen === 1'b1)
      assert_reset_idle_R1: assert (serOut && !rxValid && txReady);
  end

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rxValid |=> !rxValid);

  assert_busy_on_valid_R6: assert property (@(posedge clk) disable iff (rst)
    rxValid |-> !serOut);

  assert_short_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (rxValid && rxShort) |-> (rxData[LONG_W-1:SHORT_W] == '0));

  assert_tx_take_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(txReady) |-> $past(txValid));
endmodule

bind dbgser_port dbgser_port_chk #(.LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_chk (
  .clk(clk), .rst(rst), .serOut(serOut), .rxValid(rxValid),
  .rxShort(rxShort), .rxData(rxData), .txReady(txReady), .txValid(txValid));

// File: tb/sim_dbgser_port.sv
module sim_dbgser_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic serClk = 1'b0, serIn = 1'b0, coreIrq = 1'b0, rxAck = 1'b0, txValid = 1'b0;
  logic [31:0] txData = '0;
  logic serOut, rxCtrl, rxShort, rxValid, txReady;
  logic [31:0] rxData;

  int tests = 0, fails = 0;
  int pulses = 0, highCycles = 0;
  logic prevValid = 1'b0;
  logic [31:0] capData = '0;
  logic capCtrl = 1'b0, capShort = 1'b0;

  dbgser_port u0 (
    .clk(clk), .rst(rst), .serClk(serClk), .serIn(serIn), .serOut(serOut),
    .coreIrq(coreIrq), .rxData(rxData), .rxCtrl(rxCtrl), .rxShort(rxShort),
    .rxValid(rxValid), .rxAck(rxAck), .txData(txData), .txValid(txValid),
    .txReady(txReady));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rxValid) begin
      highCycles++;
      capData  = rxData;
      capCtrl  = rxCtrl;
      capShort = rxShort;
      if (!prevValid) pulses++;
    end
    prevValid = rxValid;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic serialBit(input logic din, output logic dout);
    serIn = din;
    repeat (HALF) @(negedge clk);
    dout = serOut;
    serClk = 1'b1;
    repeat (HALF) @(negedge clk);
    serClk = 1'b0;
  endtask

  task automatic runFrame(input logic mode, input logic ctrl, input logic [31:0] din,
                          output logic rdy, output logic [1:0] st, output logic [31:0] dout);
    int len;
    logic b;
    len = mode ? 7 : 32;
    serialBit(1'b1, rdy);
    serialBit(mode, st[1]);
    serialBit(ctrl, st[0]);
    dout = '0;
    for (int i = 0; i < len; i++) begin
      serialBit(din[i], b);
      dout[i] = b;
    end
    serIn = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic loadTx(input logic [31:0] w);
    @(negedge clk);
    txData = w;
    txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic ackWord();
    @(negedge clk);
    rxAck = 1'b1;
    @(negedge clk);
    rxAck = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic testReset();
    chk("R1 serOut", serOut, 1);
    chk("R1 rxValid", rxValid, 0);
    chk("R1 txReady", txReady, 1);
  endtask

  task automatic testIdleClocks();
    logic d;
    int p0 = pulses;
    for (int i = 0; i < 3; i++) serialBit(1'b0, d);
    repeat (HALF) @(negedge clk);
    chk("R2 idle serOut", serOut, 1);
    chk("R2 no delivery", pulses - p0, 0);
  endtask

  task automatic testNullShort();
    logic r; logic [1:0] st; logic [31:0] d;
    int p0 = pulses, h0 = highCycles;
    runFrame(1'b1, 1'b1, 32'h0000_0055, r, st, d);
    chk("R2 ready bit", r, 1);
    chk("R3 null status", st, 2'b11);
    chk("R4 null data", d, 0);
    chk("R5 short data", capData, 32'h55);
    chk("R5 ctrl bit", capCtrl, 1);
    chk("R5 short flag", capShort, 1);
    chk("R6 one pulse", pulses - p0, 1);
    chk("R6 pulse width", highCycles - h0, 1);
    chk("R6 busy", serOut, 0);
    ackWord();
    chk("R7 ready after ack", serOut, 1);
  endtask

  task automatic testValidLong();
    logic r; logic [1:0] st; logic [31:0] d;
    loadTx(32'hA5C3_1E69);
    chk("R10 txReady low when held", txReady, 0);
    runFrame(1'b0, 1'b0, 32'h1234_5678, r, st, d);
    chk("R3 valid status", st, 2'b00);
    chk("R4 long data", d, 32'hA5C3_1E69);
    chk("R5 long rx", capData, 32'h1234_5678);
    chk("R5 long flags", {capCtrl, capShort}, 2'b00);
    chk("R10 consumed", txReady, 1);
    ackWord();
  endtask

  task automatic testValidShort();
    logic r; logic [1:0] st; logic [31:0] d;
    loadTx(32'hFFFF_FFAB);
    runFrame(1'b1, 1'b0, 32'hFFFF_FF7F, r, st, d);
    chk("R3 short valid status", st, 2'b00);
    chk("R4 short low bits", d, 32'h2B);
    chk("R5 upper clear", capData, 32'h7F);
    chk("R10 consumed short", txReady, 1);
  endtask

  task automatic testSeqErr();
    logic r; logic [1:0] st; logic [31:0] d;
    int p0;
    loadTx(32'h0BAD_F00D);
    p0 = pulses;
    runFrame(1'b0, 1'b1, 32'hCAFE_0001, r, st, d);
    chk("R8 busy ready bit", r, 0);
    chk("R8 seq status", st, 2'b01);
    chk("R4 seq zero data", d, 0);
    chk("R8 no delivery", pulses - p0, 0);
    chk("R8 still busy", serOut, 0);
    chk("R8 tx kept", txReady, 0);
    chk("R8 old word", capData, 32'h7F);
    ackWord();
    chk("R7 ready again", serOut, 1);
  endtask

  task automatic testIrq();
    logic r; logic [1:0] st; logic [31:0] d;
    coreIrq = 1'b1;
    runFrame(1'b1, 1'b0, 32'h0000_0011, r, st, d);
    coreIrq = 1'b0;
    chk("R9 irq status", st, 2'b10);
    chk("R9 zero data", d, 0);
    chk("R9 tx kept", txReady, 0);
    chk("R5 irq rx", capData, 32'h11);
    ackWord();
    runFrame(1'b0, 1'b0, 32'h0, r, st, d);
    chk("R9 kept word sent", d, 32'h0BAD_F00D);
    chk("R3 status after irq", st, 2'b00);
    ackWord();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rst = 1'b0;
    repeat (4) @(negedge clk);
    testReset();
    testIdleClocks();
    testNullShort();
    testValidLong();
    testValidShort();
    testSeqErr();
    testIrq();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule